// File: doc/BRIEF.md
# ADC Result Window Watchdog

This block sits beside the conversion sequencer of an analog-to-digital converter. Each finished conversion arrives as a data word, the number of the channel it came from, and a one-cycle valid strobe. When the watchdog is enabled and the result belongs to a monitored channel, the block compares the word against a programmable lower bound and upper bound. A result outside that window sets a sticky out-of-range flag. The flag stays set until software pulses a write-one-to-clear strobe. A maskable interrupt line follows the flag.

A mode input picks which results are monitored. In one-channel mode, only results whose channel number equals a configured index are checked. In sequence mode, every channel whose bit is set in the sequence-enable mask is checked. Results from any other channel are never compared.

The flag is held by a two-state machine. In ST_CLEAR the flag reads 0. The trip transition (ST_CLEAR to ST_TRIP) fires on a qualified violation. In ST_TRIP the flag reads 1. The release transition (ST_TRIP to ST_CLEAR) fires on a clear strobe with no violation in the same cycle.

Top module: `adc_window_guard`

## Requirements
- R1: After reset, `flag` is 0 and `irq` is 0.
- R2: While `enable` is 0, no result changes `flag` from 0 to 1.
- R3: With `single_mode` = 1, a result is compared only when `res_chan` equals `watch_chan`.
- R4: With `single_mode` = 0, a result is compared only when bit `res_chan` of `seq_mask` is 1. Results from channels whose mask bit is 0 are ignored.
- R5: Both bounds are inclusive. A compared result with `thr_low <= res_data <= thr_high` never sets `flag`. A compared result below `thr_low` or above `thr_high` sets it.
- R6: Comparison happens only in a cycle where `res_valid` is 1. A violating result sampled at a rising clock edge shows on `flag` after that same edge, that is, one clock later.
- R7: Once set, `flag` stays 1 while `flag_clr` is 0. This holds across in-window results and across `enable` going to 0.
- R8: A `flag_clr` pulse returns `flag` to 0 one clock later. If a qualified violation arrives in the same cycle as the clear, `flag` stays 1.
- R9: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R10: When `thr_low` is greater than `thr_high`, every compared result counts as a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Watchdog enable |
| single_mode | input | 1 | 1: watch one channel; 0: watch every channel set in the mask |
| watch_chan | input | CH_W | Channel index watched in one-channel mode |
| seq_mask | input | NUM_CH | Sequence-enable bit per channel |
| thr_low | input | DATA_W | Lower window bound (inclusive) |
| thr_high | input | DATA_W | Upper window bound (inclusive) |
| res_valid | input | 1 | One-cycle strobe marking a finished conversion |
| res_data | input | DATA_W | Conversion result |
| res_chan | input | CH_W | Channel number of the result |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| irq_en | input | 1 | Interrupt mask |
| flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DATA_W = 4 and NUM_CH = 4. At that size every combination of lower bound, upper bound and result value (4096 cases) can be swept, including inverted windows and both bound edges. Every one-channel pairing of watched index and result channel is covered, as is every sequence mask against every result channel. Expected flags come from plain comparisons and mask lookups done in the bench itself.

// File: rtl/adc_window_guard_pkg.sv
package adc_window_guard_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_TRIP  = 1'b1
    } guard_state_e;

    typedef enum logic {
        SEL_SEQUENCE = 1'b0,
        SEL_SINGLE   = 1'b1
    } guard_sel_e;

endpackage

// File: rtl/awg_chan_select.sv
module awg_chan_select
    import adc_window_guard_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  guard_sel_e        sel_mode,
    input  logic [CH_W-1:0]   watch_chan,
    input  logic [NUM_CH-1:0] seq_mask,
    input  logic [CH_W-1:0]   res_chan,
    output logic              watched
);
    logic [NUM_CH-1:0] chan_hot;

    // Decode the result channel into one bit per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hot
        assign chan_hot[i] = (res_chan == CH_W'(i));
    end

    logic in_seq;
    logic is_single;

    assign in_seq    = |(chan_hot & seq_mask);
    assign is_single = (res_chan == watch_chan);

    always_comb begin
        unique case (sel_mode)
            SEL_SINGLE:   watched = is_single;
            SEL_SEQUENCE: watched = in_seq;
            default:      watched = 1'b0;
        endcase
    end
endmodule

// File: rtl/awg_window_cmp.sv
module awg_window_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output logic              outside
);
    logic below;
    logic above;

    assign below   = (value < lo);
    assign above   = (value > hi);
    assign outside = below | above;
endmodule

// File: rtl/awg_flag_fsm.sv
module awg_flag_fsm
    import adc_window_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    guard_state_e state_q;
    guard_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (trip) state_d = ST_TRIP;
            ST_TRIP:  if (clr && !trip) state_d = ST_CLEAR;
            default:  state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_TRIP:  flag = 1'b1;
            ST_CLEAR: flag = 1'b0;
            default:  flag = 1'b0;
        endcase
        irq = flag & irq_en;
    end
endmodule

// File: rtl/adc_window_guard.sv
module adc_window_guard
    import adc_window_guard_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              single_mode,
    input  logic [CH_W-1:0]   watch_chan,
    input  logic [NUM_CH-1:0] seq_mask,
    input  logic [DATA_W-1:0] thr_low,
    input  logic [DATA_W-1:0] thr_high,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              flag,
    output logic              irq
);
    guard_sel_e sel_mode;
    logic       watched;
    logic       outside;
    logic       trip;

    assign sel_mode = single_mode ? SEL_SINGLE : SEL_SEQUENCE;

    awg_chan_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
        .sel_mode   (sel_mode),
        .watch_chan (watch_chan),
        .seq_mask   (seq_mask),
        .res_chan   (res_chan),
        .watched    (watched)
    );

    awg_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .value   (res_data),
        .lo      (thr_low),
        .hi      (thr_high),
        .outside (outside)
    );

    // A violation counts only on a strobe, while enabled, for a watched channel.
    assign trip = res_valid & enable & watched & outside;

    awg_flag_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip   (trip),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (flag),
        .irq    (irq)
    );
endmodule

// File: rtl/adc_window_guard_sva.sv
module adc_window_guard_sva #(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              single_mode,
    input logic [CH_W-1:0]   watch_chan,
    input logic [NUM_CH-1:0] seq_mask,
    input logic [DATA_W-1:0] thr_low,
    input logic [DATA_W-1:0] thr_high,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [CH_W-1:0]   res_chan,
    input logic              flag_clr,
    input logic              irq_en,
    input logic              flag,
    input logic              irq
);
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !enable) |=> !flag);

    assert_single_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && enable && single_mode && res_chan == watch_chan
         && (res_data < thr_low || res_data > thr_high)) |=> flag);

    assert_single_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && single_mode && res_chan != watch_chan) |=> !flag);

    assert_inside_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && res_valid && res_data >= thr_low && res_data <= thr_high) |=> !flag);

    assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !res_valid) |=> !flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !res_valid) |=> !flag);

    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (flag && irq_en));
endmodule

bind adc_window_guard adc_window_guard_sva #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .enable(enable), .single_mode(single_mode),
    .watch_chan(watch_chan), .seq_mask(seq_mask), .thr_low(thr_low),
    .thr_high(thr_high), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .flag_clr(flag_clr), .irq_en(irq_en),
    .flag(flag), .irq(irq)
);

// File: tb/adc_window_guard_test.sv
`timescale 1ns/1ps
module adc_window_guard_test;
    localparam int DW = 4;
    localparam int NC = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          single_mode = 1'b0;
    logic [CW-1:0] watch_chan = '0;
    logic [NC-1:0] seq_mask = '0;
    logic [DW-1:0] thr_low = '0;
    logic [DW-1:0] thr_high = '1;
    logic          res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [CW-1:0] res_chan = '0;
    logic          flag_clr = 1'b0;
    logic          irq_en = 1'b0;
    logic          flag;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_window_guard #(.DATA_W(DW), .NUM_CH(NC)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .single_mode(single_mode),
        .watch_chan(watch_chan), .seq_mask(seq_mask), .thr_low(thr_low),
        .thr_high(thr_high), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .flag_clr(flag_clr), .irq_en(irq_en),
        .flag(flag), .irq(irq)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    // Present one result for one cycle; on return the flag after that edge is visible.
    task automatic pulse(input logic [DW-1:0] d, input logic [CW-1:0] c);
        @(negedge clk);
        res_valid = 1'b1; res_data = d; res_chan = c;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(flag, 1'b0, "R1 flag");
        check(irq, 1'b0, "R1 irq");
        rst_n = 1'b1;
        @(negedge clk);
        check(flag, 1'b0, "R1 flag after release");

        // R2: disabled watchdog ignores every value
        enable = 1'b0; single_mode = 1'b1; watch_chan = 2'd1;
        thr_low = 4'd5; thr_high = 4'd9;
        for (int d = 0; d < 16; d++) begin
            pulse(DW'(d), 2'd1);
            check(flag, 1'b0, "R2 disabled");
        end

        // R5 and R10: exhaustive window sweep in one-channel mode
        enable = 1'b1;
        for (int lo = 0; lo < 16; lo++) begin
            for (int hi = 0; hi < 16; hi++) begin
                thr_low = DW'(lo); thr_high = DW'(hi);
                for (int d = 0; d < 16; d++) begin
                    clear_flag();
                    pulse(DW'(d), 2'd1);
                    check(flag, (d < lo) || (d > hi), lo > hi ? "R10 inverted window" : "R5 window");
                end
            end
        end

        // R3: one-channel mode, every watched/result pairing
        thr_low = 4'd4; thr_high = 4'd10;
        single_mode = 1'b1;
        for (int w = 0; w < NC; w++) begin
            for (int c = 0; c < NC; c++) begin
                watch_chan = CW'(w);
                clear_flag();
                pulse(4'd15, CW'(c));
                check(flag, w == c, "R3 single channel");
            end
        end

        // R4: sequence mode, every mask against every channel
        single_mode = 1'b0;
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < NC; c++) begin
                seq_mask = NC'(m);
                clear_flag();
                pulse(4'd0, CW'(c));
                check(flag, m[c], "R4 sequence mask");
            end
        end

        // R6: violating data without the strobe has no effect
        seq_mask = 4'hF;
        clear_flag();
        @(negedge clk) res_data = 4'd15; res_chan = 2'd2;
        repeat (2) @(negedge clk);
        check(flag, 1'b0, "R6 no strobe");
        // R6: flag appears exactly after the sampling edge
        @(negedge clk) res_valid = 1'b1;
        #2 check(flag, 1'b0, "R6 before edge");
        @(negedge clk) res_valid = 1'b0;
        check(flag, 1'b1, "R6 after edge");

        // R7: sticky across in-window result and disable
        pulse(4'd6, 2'd2);
        check(flag, 1'b1, "R7 in-window keeps flag");
        @(negedge clk) enable = 1'b0;
        repeat (3) @(negedge clk);
        check(flag, 1'b1, "R7 disable keeps flag");
        enable = 1'b1;

        // R9: interrupt masking
        irq_en = 1'b0; #1;
        check(irq, 1'b0, "R9 masked");
        irq_en = 1'b1; #1;
        check(irq, 1'b1, "R9 unmasked");

        // R8: violation wins over a simultaneous clear
        @(negedge clk);
        flag_clr = 1'b1; res_valid = 1'b1; res_data = 4'd15; res_chan = 2'd0;
        @(negedge clk);
        flag_clr = 1'b0; res_valid = 1'b0;
        check(flag, 1'b1, "R8 violation beats clear");
        // R8: plain clear
        clear_flag();
        check(flag, 1'b0, "R8 clear");
        #1 check(irq, 1'b0, "R9 cleared");
        // R8: clear with an in-window result in the same cycle
        pulse(4'd15, 2'd0);
        @(negedge clk);
        flag_clr = 1'b1; res_valid = 1'b1; res_data = 4'd7;
        @(negedge clk);
        flag_clr = 1'b0; res_valid = 1'b0;
        check(flag, 1'b0, "R8 clear with in-window result");

        finish_run();
    end
endmodule